// File: doc/BRIEF.md
# Restart Request and Stop Controller

This block gathers restart requests from five places: standby entry, a software alarm, an external test monitor, a digital voltage-transient detector and a severe analog alarm. It lines them up with a twelve-step timepulse generator that paces every memory cycle. A request is caught at once in a pending flag, but it only reaches the machine at the last step of the cycle. That lets the cycle in flight finish cleanly. Once it takes effect, the block drives a global restart line and a stop line. The stop line freezes the timepulse generator on its last step.

The severe analog alarm skips the wait. It cuts the cycle short and jumps the generator straight to the last step. The restart holds until the sequencer answers that the restart instruction sequence has been selected. The generator then resumes at step one.

A separate monitor halt lets the running cycle reach its last step and parks the machine there, with no reset, for as long as the halt is held. All request inputs are active high and are sampled on the rising clock edge. Reset is synchronous and active low.

Top module: `restart_stop_ctl`

## Requirements
- R1: During and right after synchronous reset, tp_o reads 12, restart_o is 1 and stop_o is 1.
- R2: When not held, tp_o steps by one per clock through 1, 2, …, 12 as a binary value, and returns from 12 to 1.
- R3: A one-cycle pulse on any of req_standby, req_sw_alarm, req_monitor or req_volt sampled while tp_o is below 12 leaves restart_o low for the rest of that cycle. restart_o rises on the clock edge at which tp_o is 12, and tp_o stays at 12.
- R4: A request on an ordinary source sampled on the edge where tp_o is 12 does not stop that edge. tp_o goes on to 1, a full cycle runs, and restart_o rises at the next step 12.
- R5: While stop_o is 1, tp_o stays at 12, and an unanswered restart keeps restart_o and stop_o at 1 for any number of cycles.
- R6: req_severe sampled on any edge sets restart_o and stop_o to 1 and tp_o to 12 after that edge, whatever step was current.
- R7: seq_selected sampled while restart_o is 1 clears restart_o, and clears stop_o unless a halt holds it. tp_o then moves to 1 on that edge. seq_selected sampled while restart_o is 0 has no effect: a request already pending still restarts at the next step 12.
- R8: An ordinary request still high when seq_selected is accepted stays pending, so restart_o rises again at the next step 12.
- R9: mon_halt raised mid-cycle lets tp_o run to 12. stop_o then goes to 1 with restart_o at 0, and tp_o stays at 12 until mon_halt falls. On the edge that samples mon_halt low, stop_o clears and tp_o becomes 1.
- R10: When a halt and a restart overlap, the restart proceeds normally. stop_o stays 1 and tp_o stays 12 until both the restart has been answered and mon_halt is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_standby | input | 1 | Restart request on standby entry |
| req_sw_alarm | input | 1 | Restart request from a software alarm |
| req_monitor | input | 1 | Restart request injected by the test monitor |
| req_volt | input | 1 | Restart request from the voltage-transient detector |
| req_severe | input | 1 | Severe analog alarm, restarts at once |
| mon_halt | input | 1 | Monitor halt without reset, level sensitive |
| seq_selected | input | 1 | Acknowledge that the restart sequence has been selected |
| restart_o | output | 1 | Global restart |
| stop_o | output | 1 | Timepulse freeze |
| tp_o | output | TPW | Current timepulse, 1 to 12 |

## Verification
A pending flag that is lost or that sticks shows up at the next step 12. Either restart_o fails to rise, or it rises again after an acknowledge, at most twelve cycles after the faulty edge. A wrong timepulse count shows on tp_o on the very next edge, and it also moves the point where a restart or halt lands. A halt or restart register that clears early lets tp_o leave 12 while stop_o should hold it. The bench checks all three outputs on every cycle against a step-by-step expectation, so any such fault appears within one memory cycle of its cause.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    localparam int TP_COUNT_DEF = 12;
    localparam int NUM_SOFT_SRC = 4;

    typedef struct packed {
        logic pend;
        logic det;
    } latch_state_t;

    typedef struct packed {
        logic halted;
    } halt_state_t;

endpackage

// File: rtl/rsc_restart_latch.sv
module rsc_restart_latch #(
    parameter int NUM_SRC = rsc_pkg::NUM_SOFT_SRC,
    parameter int TPW     = 4,
    parameter int TP_LAST = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] soft_req,
    input  logic               severe,
    input  logic               ack,
    input  logic [TPW-1:0]     tp_q,
    output logic               restart_q,
    output logic               restart_d
);
    import rsc_pkg::*;

    latch_state_t st_q, st_d;
    logic any_req;
    logic release_now;
    logic at_last;

    always_comb begin
        any_req     = (|soft_req) | severe;
        release_now = ack & st_q.det;
        at_last     = (tp_q == TPW'(TP_LAST));
        st_d        = st_q;
        st_d.pend   = any_req | (st_q.pend & ~release_now);
        if (severe) begin
            st_d.det = 1'b1;
        end else if (release_now) begin
            st_d.det = 1'b0;
        end else if (st_q.pend && at_last) begin
            st_d.det = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{pend: 1'b1, det: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign restart_q = st_q.det;
    assign restart_d = st_d.det;

    assert_severe_immediate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        severe |=> restart_q);

    assert_ack_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && restart_q && !severe) |=> !restart_q);

    assert_rise_only_at_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restart_q) |-> ($past(tp_q) == TPW'(TP_LAST) || $past(severe)));

    assert_pending_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !(ack && restart_q)) |=> st_q.pend);

endmodule

// File: rtl/rsc_halt.sv
module rsc_halt #(
    parameter int TPW     = 4,
    parameter int TP_LAST = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           halt_req,
    input  logic [TPW-1:0] tp_q,
    output logic           halt_q,
    output logic           halt_d
);
    import rsc_pkg::*;

    halt_state_t st_q, st_d;

    always_comb begin
        st_d        = st_q;
        st_d.halted = halt_req & (st_q.halted | (tp_q == TPW'(TP_LAST)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{halted: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign halt_q = st_q.halted;
    assign halt_d = st_d.halted;

    assert_halt_waits_for_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !halt_q && tp_q != TPW'(TP_LAST)) |=> !halt_q);

    assert_halt_drops_with_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_req |=> !halt_q);

endmodule

// File: rtl/rsc_timepulse.sv
module rsc_timepulse #(
    parameter int TPW     = 4,
    parameter int TP_LAST = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hold_d,
    input  logic           abort,
    output logic [TPW-1:0] tp_q
);
    typedef struct packed {
        logic [TPW-1:0] step;
    } tp_state_t;

    localparam logic [TPW-1:0] LAST  = TPW'(TP_LAST);
    localparam logic [TPW-1:0] FIRST = TPW'(1);

    tp_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (abort) begin
            st_d.step = LAST;
        end else if (st_q.step == LAST) begin
            st_d.step = hold_d ? LAST : FIRST;
        end else begin
            st_d.step = st_q.step + FIRST;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{step: LAST};
        end else begin
            st_q <= st_d;
        end
    end

    assign tp_q = st_q.step;

    assert_steps_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tp_q) != LAST && !$past(abort)) |-> tp_q == $past(tp_q) + FIRST);

    assert_step_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tp_q >= FIRST && tp_q <= LAST));

endmodule

// File: rtl/restart_stop_ctl.sv
module restart_stop_ctl #(
    parameter int TP_COUNT = rsc_pkg::TP_COUNT_DEF,
    parameter int TPW      = $clog2(TP_COUNT + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_standby,
    input  logic           req_sw_alarm,
    input  logic           req_monitor,
    input  logic           req_volt,
    input  logic           req_severe,
    input  logic           mon_halt,
    input  logic           seq_selected,
    output logic           restart_o,
    output logic           stop_o,
    output logic [TPW-1:0] tp_o
);
    import rsc_pkg::*;

    localparam int NSRC = NUM_SOFT_SRC;

    logic [NSRC-1:0] soft_req;
    logic            rst_now, rst_next;
    logic            hlt_now, hlt_next;
    logic            hold_next;
    logic [TPW-1:0]  tp_cur;

    always_comb begin
        soft_req  = {req_standby, req_sw_alarm, req_monitor, req_volt};
        hold_next = rst_next | hlt_next;
    end

    rsc_restart_latch #(.NUM_SRC(NSRC), .TPW(TPW), .TP_LAST(TP_COUNT)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_req  (soft_req),
        .severe    (req_severe),
        .ack       (seq_selected),
        .tp_q      (tp_cur),
        .restart_q (rst_now),
        .restart_d (rst_next)
    );

    rsc_halt #(.TPW(TPW), .TP_LAST(TP_COUNT)) u_halt (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_req (mon_halt),
        .tp_q     (tp_cur),
        .halt_q   (hlt_now),
        .halt_d   (hlt_next)
    );

    rsc_timepulse #(.TPW(TPW), .TP_LAST(TP_COUNT)) u_tp (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_d (hold_next),
        .abort  (req_severe),
        .tp_q   (tp_cur)
    );

    assign restart_o = rst_now;
    assign stop_o    = rst_now | hlt_now;
    assign tp_o      = tp_cur;

    assert_stop_pins_tp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> tp_o == TPW'(TP_COUNT));

    assert_stop_leaves_to_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stop_o) && !$past(req_severe)) |-> tp_o == TPW'(1));

endmodule

// File: tb/restart_stop_ctl_test.sv
`timescale 1ns/1ps
module restart_stop_ctl_test;

    localparam int TPC = 12;
    localparam int W   = $clog2(TPC + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_standby = 0, req_sw_alarm = 0, req_monitor = 0, req_volt = 0, req_severe = 0;
    logic mon_halt = 0, seq_selected = 0;
    logic restart_o, stop_o;
    logic [W-1:0] tp_o;

    always #2 clk = ~clk;

    restart_stop_ctl #(.TP_COUNT(TPC)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_standby(req_standby), .req_sw_alarm(req_sw_alarm),
        .req_monitor(req_monitor), .req_volt(req_volt), .req_severe(req_severe),
        .mon_halt(mon_halt), .seq_selected(seq_selected),
        .restart_o(restart_o), .stop_o(stop_o), .tp_o(tp_o)
    );

    int    applied = 0;
    int    bad     = 0;
    bit    finished = 0;
    int    q_tp[$];
    bit    q_rs[$];
    bit    q_st[$];
    string q_tag[$];

    // Expected-behaviour state, advanced once per clock from the requirements
    int m_tp;
    bit m_pend, m_rs, m_halt;

    // Driver: drive inputs at negedge, predict the outputs after the next edge
    task automatic step(input string tag, input bit rst, input logic [4:0] r,
                        input bit halt, input bit ack);
        bit any, clr, n_pend, n_rs, n_halt;
        int n_tp;
        @(negedge clk);
        rst_n        = ~rst;
        req_standby  = r[0];
        req_sw_alarm = r[1];
        req_monitor  = r[2];
        req_volt     = r[3];
        req_severe   = r[4];
        mon_halt     = halt;
        seq_selected = ack;
        if (rst) begin
            m_tp = TPC; m_pend = 1; m_rs = 1; m_halt = 0;
        end else begin
            any    = |r;
            clr    = ack && m_rs;
            n_pend = any || (m_pend && !clr);
            if (r[4])                      n_rs = 1;
            else if (clr)                  n_rs = 0;
            else if (m_pend && m_tp == TPC) n_rs = 1;
            else                           n_rs = m_rs;
            n_halt = halt && (m_halt || m_tp == TPC);
            if (r[4])              n_tp = TPC;
            else if (m_tp == TPC)  n_tp = (n_rs || n_halt) ? TPC : 1;
            else                   n_tp = m_tp + 1;
            m_tp = n_tp; m_pend = n_pend; m_rs = n_rs; m_halt = n_halt;
        end
        q_tp.push_back(m_tp);
        q_rs.push_back(m_rs);
        q_st.push_back(m_rs || m_halt);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 0, 5'b0, 0, 0);
    endtask

    task automatic run_to(input string tag, input int t, input bit halt);
        for (int i = 0; i < 40 && m_tp != t; i++) step(tag, 0, 5'b0, halt, 0);
    endtask

    // Monitor: compare just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_tp.size() > 0) begin
                int    e_tp;
                bit    e_rs, e_st;
                string tg;
                e_tp = q_tp.pop_front();
                e_rs = q_rs.pop_front();
                e_st = q_st.pop_front();
                tg   = q_tag.pop_front();
                applied++;
                if (tp_o !== W'(e_tp) || restart_o !== e_rs || stop_o !== e_st) begin
                    bad++;
                    $display("FAIL %s: tp/restart/stop got %0d/%0b/%0b expected %0d/%0b/%0b",
                             tg, tp_o, restart_o, stop_o, e_tp, e_rs, e_st);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: run did not complete, got hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) step("R1 reset", 1, 5'b0, 0, 0);
        idle("R1 after reset", 1);
        idle("R5 unanswered restart holds", 4);
        step("R7 ack releases", 0, 5'b0, 0, 1);
        idle("R2 stepping", 26);

        // R3: ordinary request mid-cycle
        run_to("R2 stepping", 5, 0);
        step("R3 volt pulse", 0, 5'b01000, 0, 0);
        run_to("R3 waits for step 12", TPC, 0);
        idle("R5 held at 12", 5);
        step("R7 ack", 0, 5'b0, 0, 1);

        // R7: ack with nothing asserted is ignored; pending request survives it
        run_to("R2", 3, 0);
        step("R7 idle ack ignored", 0, 5'b0, 0, 1);
        step("R7 standby pulse", 0, 5'b00001, 0, 0);
        step("R7 ack while pending ignored", 0, 5'b0, 0, 1);
        run_to("R7 pending survives", TPC, 0);
        idle("R5 held", 2);
        step("R7 ack", 0, 5'b0, 0, 1);

        // R4: request sampled right at step 12
        run_to("R2", TPC, 0);
        step("R4 sw alarm at step 12", 0, 5'b00010, 0, 0);
        idle("R4 full cycle runs", 12);
        idle("R4 restart at next 12", 2);
        step("R7 ack", 0, 5'b0, 0, 1);

        // R6: severe alarm mid-cycle
        run_to("R2", 6, 0);
        step("R6 severe aborts", 0, 5'b10000, 0, 0);
        idle("R6 held", 3);
        step("R7 ack", 0, 5'b0, 0, 1);
        run_to("R2", 1, 0);
        step("R6 severe at step 1", 0, 5'b10000, 0, 0);
        step("R7 ack", 0, 5'b0, 0, 1);

        // R8: request held through ack
        run_to("R2", 4, 0);
        for (int i = 0; i < 10; i++) step("R8 monitor req held", 0, 5'b00100, 0, 0);
        step("R8 ack with req high", 0, 5'b00100, 0, 1);
        idle("R8 re-restart", 14);
        step("R7 ack", 0, 5'b0, 0, 1);

        // R9: halt without reset
        run_to("R2", 3, 0);
        for (int i = 0; i < 30; i++) step("R9 halt", 0, 5'b0, 1, 0);
        idle("R9 release", 4);

        // R10: halt overlapping restart
        run_to("R2", 7, 0);
        step("R10 halt plus volt", 0, 5'b01000, 1, 0);
        for (int i = 0; i < 8; i++) step("R10 halt", 0, 5'b0, 1, 0);
        step("R10 ack under halt", 0, 5'b0, 1, 1);
        for (int i = 0; i < 4; i++) step("R10 stop held by halt", 0, 5'b0, 1, 0);
        idle("R10 both cleared", 3);
        run_to("R2", TPC, 1);
        step("R10 severe under halt", 0, 5'b10000, 1, 0);
        step("R10 halt drops first", 0, 5'b0, 0, 0);
        idle("R10 restart still held", 2);
        step("R10 ack", 0, 5'b0, 0, 1);
        idle("R2 tail", 14);

        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

endmodule